// File: doc/BRIEF.md
# Pre-decoded Instruction Fetch Store

A small direct-mapped instruction store that feeds a fetch unit. Every entry carries the instruction word, a two-bit kind code and the full address of the instruction to fetch next. The fetch unit loads its lookup address straight from that stored successor field on every hit, so the hit path has no sequential-address adder. Unconditional jumps are folded into the entry before them: that entry's successor field already names the jump target, so the jump costs no cycle. Conditional branches are predicted taken: the branch entry's successor field holds its target.

A fill port writes pre-decoded entries. It is driven by an external refill and predecode path. A resolution input reports the real outcome of a branch. A not-taken outcome drops the lookup under way, sends a one-cycle squash strobe and resumes fetch after the branch. A folded call still needs its return address written to the register file. That write competes with the preceding instruction's own write, so a small holder keeps the return address until the write port is free and stalls fetch in the meantime.

Top module: `pdc_fetch`

## Requirements
- R1: During and right after reset, fetch_valid_o, squash_o and link_valid_o are low and fetch_addr_o equals the reset address (0 by default).
- R2: When the entry selected by fetch_addr_o is empty or holds another tag, miss_o is high. On the next cycle fetch_valid_o is low and fetch_addr_o is unchanged. A fill to that address is written at the clock edge, and the held address hits in the following cycle.
- R3: The store has 16 entries selected by address bits [5:2], with bits [31:6] kept as the tag. A hit delivers the filled instruction, kind and successor verbatim on the next cycle, with fetch_pc_o equal to the looked-up address. An address with the same index and a different tag misses.
- R4: After a hit is delivered, fetch_addr_o equals the delivered entry's successor field; a sequential entry (kind 0) at address A holds A+4. Back-to-back hits deliver one instruction per cycle with no gap.
- R5: An entry with a folded jump (kind 1) is followed in the very next cycle by delivery of the jump target; no cycle is spent on the jump itself.
- R6: A branch entry (kind 3) is followed in the next cycle by a lookup of its target (predict taken).
- R7: A resolution with resolve_taken_i low drops the lookup of that cycle. On the next cycle fetch_valid_o is low, squash_o is high for exactly one cycle, and fetch_addr_o equals resolve_pc_i+4.
- R8: A resolution with resolve_taken_i high has no effect on fetch_addr_o, miss_o, fetch_valid_o or squash_o.
- R9: An entry with a folded call (kind 2) is delivered together with link_valid_o high and link_addr_o equal to its own address plus 8, which is the return address of the call folded behind it.
- R10: While link_valid_o and wb_busy_i are both high, fetch stalls: on the next cycle fetch_valid_o is low, fetch_addr_o is unchanged, and the return address is still held.
- R11: After a cycle with link_valid_o high and wb_busy_i low, the return address has been written and link_valid_o falls, unless a new folded call is delivered in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Write a pre-decoded entry this cycle |
| fill_addr_i | input | 32 | Address of the entry being written |
| fill_instr_i | input | 32 | Instruction word of the entry |
| fill_kind_i | input | 2 | Kind: 0 sequential, 1 folded jump, 2 folded call, 3 branch |
| fill_next_i | input | 32 | Successor address stored in the entry |
| resolve_valid_i | input | 1 | Branch outcome reported this cycle |
| resolve_taken_i | input | 1 | Reported branch was taken |
| resolve_pc_i | input | 32 | Address of the resolved branch |
| wb_busy_i | input | 1 | Register-file write port taken by another write this cycle |
| fetch_addr_o | output | 32 | Address being looked up this cycle |
| miss_o | output | 1 | Lookup of fetch_addr_o misses |
| fetch_valid_o | output | 1 | A fetched instruction is delivered |
| fetch_pc_o | output | 32 | Address of the delivered instruction |
| fetch_instr_o | output | 32 | Delivered instruction word |
| fetch_kind_o | output | 2 | Kind of the delivered entry |
| fetch_next_o | output | 32 | Successor field of the delivered entry |
| squash_o | output | 1 | One-cycle strobe: a mispredicted lookup was dropped and fetch restarted |
| link_valid_o | output | 1 | A folded call's return address is waiting for the write port |
| link_addr_o | output | 32 | That return address |

## Verification
The bench fills a short program whose path runs through a folded jump, a predicted-taken branch and a folded call. It checks that the program streams out with no bubble. A design that added an address instead of using the stored successor, or that spent a cycle on the jump, would deliver the wrong sequence or leave a gap. A not-taken resolution is raised while the branch target is being looked up: a design that let the target through, held the strobe too long or restarted at the branch itself would be caught. Other cases hit an index that holds a different tag, where a design without a tag compare returns stale data. The last case holds the write port busy around a folded call, so a design that dropped the return address or kept fetching would fail.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic [1:0] {
    KIND_SEQ  = 2'd0,
    KIND_JMP  = 2'd1,
    KIND_CALL = 2'd2,
    KIND_BR   = 2'd3
  } kind_e;
endpackage

// File: rtl/pdc_store.sv
module pdc_store
  import pdc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [INSTR_W-1:0] wr_instr_i,
  input  kind_e              wr_kind_i,
  input  logic [ADDR_W-1:0]  wr_next_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic               rd_hit_o,
  output logic [INSTR_W-1:0] rd_instr_o,
  output kind_e              rd_kind_o,
  output logic [ADDR_W-1:0]  rd_next_o
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int LO      = 2;
  localparam int TAG_W   = ADDR_W - IDX_W - LO;

  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [TAG_W-1:0] wr_tag, rd_tag;
  assign wr_idx = wr_addr_i[IDX_W+LO-1:LO];
  assign rd_idx = rd_addr_i[IDX_W+LO-1:LO];
  assign wr_tag = wr_addr_i[ADDR_W-1:IDX_W+LO];
  assign rd_tag = rd_addr_i[ADDR_W-1:IDX_W+LO];

  logic               unused_lo;
  assign unused_lo = ^{wr_addr_i[LO-1:0], rd_addr_i[LO-1:0]};

  logic [ENTRIES-1:0] vld_v;
  logic [TAG_W-1:0]   tag_a   [ENTRIES];
  logic [INSTR_W-1:0] instr_a [ENTRIES];
  kind_e              kind_a  [ENTRIES];
  logic [ADDR_W-1:0]  next_a  [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [IDX_W-1:0] ME = IDX_W'(e);
    logic               sel;
    logic               vld_q;
    logic [TAG_W-1:0]   tag_q;
    logic [INSTR_W-1:0] instr_q;
    kind_e              kind_q;
    logic [ADDR_W-1:0]  next_q;

    assign sel = wr_en_i && (wr_idx == ME);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  vld_q <= 1'b0;
      else if (sel) vld_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q   <= wr_tag;
        instr_q <= wr_instr_i;
        kind_q  <= wr_kind_i;
        next_q  <= wr_next_i;
      end
    end

    assign vld_v[e]   = vld_q;
    assign tag_a[e]   = tag_q;
    assign instr_a[e] = instr_q;
    assign kind_a[e]  = kind_q;
    assign next_a[e]  = next_q;
  end

  assign rd_hit_o   = vld_v[rd_idx] && (tag_a[rd_idx] == rd_tag);
  assign rd_instr_o = instr_a[rd_idx];
  assign rd_kind_o  = kind_a[rd_idx];
  assign rd_next_o  = next_a[rd_idx];
endmodule

// File: rtl/pdc_link.sv
module pdc_link #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              busy_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              stall_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;

  // a new call wins over retiring the old one: the old one is written this cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
    end else if (pend_q && !busy_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign addr_o  = addr_q;
  assign stall_o = pend_q && busy_i;
endmodule

// File: rtl/pdc_pc.sv
module pdc_pc
  import pdc_pkg::*;
#(
  parameter int               ADDR_W   = 32,
  parameter int               INSTR_W  = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [INSTR_W-1:0] rd_instr_i,
  input  kind_e              rd_kind_i,
  input  logic [ADDR_W-1:0]  rd_next_i,
  input  logic               stall_i,
  input  logic               res_valid_i,
  input  logic               res_taken_i,
  input  logic [ADDR_W-1:0]  res_pc_i,
  output logic [ADDR_W-1:0]  look_pc_o,
  output logic               call_take_o,
  output logic               out_valid_o,
  output logic [ADDR_W-1:0]  out_pc_o,
  output logic [INSTR_W-1:0] out_instr_o,
  output kind_e              out_kind_o,
  output logic [ADDR_W-1:0]  out_next_o,
  output logic               squash_o
);
  logic redirect, take;
  logic [ADDR_W-1:0] pc_q;

  assign redirect    = res_valid_i && !res_taken_i;
  assign take        = hit_i && !stall_i && !redirect;
  assign call_take_o = take && (rd_kind_i == KIND_CALL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q        <= RESET_PC;
      out_valid_o <= 1'b0;
      out_pc_o    <= '0;
      out_instr_o <= '0;
      out_kind_o  <= KIND_SEQ;
      out_next_o  <= '0;
      squash_o    <= 1'b0;
    end else if (redirect) begin
      pc_q        <= res_pc_i + ADDR_W'(4);
      out_valid_o <= 1'b0;
      squash_o    <= 1'b1;
    end else begin
      squash_o    <= 1'b0;
      out_valid_o <= take;
      if (take) begin
        pc_q        <= rd_next_i;   // stored successor, no adder
        out_pc_o    <= pc_q;
        out_instr_o <= rd_instr_i;
        out_kind_o  <= rd_kind_i;
        out_next_o  <= rd_next_i;
      end
    end
  end

  assign look_pc_o = pc_q;
endmodule

// File: rtl/pdc_fetch.sv
module pdc_fetch
  import pdc_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                INSTR_W  = 32,
  parameter int                IDX_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_valid_i,
  input  logic [ADDR_W-1:0]  fill_addr_i,
  input  logic [INSTR_W-1:0] fill_instr_i,
  input  logic [1:0]         fill_kind_i,
  input  logic [ADDR_W-1:0]  fill_next_i,
  input  logic               resolve_valid_i,
  input  logic               resolve_taken_i,
  input  logic [ADDR_W-1:0]  resolve_pc_i,
  input  logic               wb_busy_i,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic               miss_o,
  output logic               fetch_valid_o,
  output logic [ADDR_W-1:0]  fetch_pc_o,
  output logic [INSTR_W-1:0] fetch_instr_o,
  output logic [1:0]         fetch_kind_o,
  output logic [ADDR_W-1:0]  fetch_next_o,
  output logic               squash_o,
  output logic               link_valid_o,
  output logic [ADDR_W-1:0]  link_addr_o
);
  logic               hit, stall, call_take;
  logic [INSTR_W-1:0] rd_instr;
  kind_e              rd_kind, out_kind;
  logic [ADDR_W-1:0]  rd_next, look_pc;

  pdc_store #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .IDX_W(IDX_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (fill_valid_i),
    .wr_addr_i  (fill_addr_i),
    .wr_instr_i (fill_instr_i),
    .wr_kind_i  (kind_e'(fill_kind_i)),
    .wr_next_i  (fill_next_i),
    .rd_addr_i  (look_pc),
    .rd_hit_o   (hit),
    .rd_instr_o (rd_instr),
    .rd_kind_o  (rd_kind),
    .rd_next_o  (rd_next)
  );

  pdc_pc #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .rd_instr_i  (rd_instr),
    .rd_kind_i   (rd_kind),
    .rd_next_i   (rd_next),
    .stall_i     (stall),
    .res_valid_i (resolve_valid_i),
    .res_taken_i (resolve_taken_i),
    .res_pc_i    (resolve_pc_i),
    .look_pc_o   (look_pc),
    .call_take_o (call_take),
    .out_valid_o (fetch_valid_o),
    .out_pc_o    (fetch_pc_o),
    .out_instr_o (fetch_instr_o),
    .out_kind_o  (out_kind),
    .out_next_o  (fetch_next_o),
    .squash_o    (squash_o)
  );

  // return address of the call folded one slot behind the looked-up entry
  pdc_link #(.ADDR_W(ADDR_W)) u_link (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (call_take),
    .addr_i  (look_pc + ADDR_W'(8)),
    .busy_i  (wb_busy_i),
    .pend_o  (link_valid_o),
    .addr_o  (link_addr_o),
    .stall_o (stall)
  );

  assign fetch_addr_o = look_pc;
  assign miss_o       = !hit;
  assign fetch_kind_o = out_kind;
endmodule

// File: rtl/pdc_fetch_chk.sv
module pdc_fetch_chk
  import pdc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int INSTR_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               fill_valid_i,
  input logic [ADDR_W-1:0]  fill_addr_i,
  input logic [INSTR_W-1:0] fill_instr_i,
  input logic [1:0]         fill_kind_i,
  input logic [ADDR_W-1:0]  fill_next_i,
  input logic               resolve_valid_i,
  input logic               resolve_taken_i,
  input logic [ADDR_W-1:0]  resolve_pc_i,
  input logic               wb_busy_i,
  input logic [ADDR_W-1:0]  fetch_addr_o,
  input logic               miss_o,
  input logic               fetch_valid_o,
  input logic [ADDR_W-1:0]  fetch_pc_o,
  input logic [INSTR_W-1:0] fetch_instr_o,
  input logic [1:0]         fetch_kind_o,
  input logic [ADDR_W-1:0]  fetch_next_o,
  input logic               squash_o,
  input logic               link_valid_o,
  input logic [ADDR_W-1:0]  link_addr_o
);
  logic unused_chk;
  assign unused_chk = ^{fill_valid_i, fill_addr_i, fill_instr_i, fill_kind_i,
                        fill_next_i, fetch_instr_o};

  logic mispredict;
  assign mispredict = resolve_valid_i && !resolve_taken_i;

  a_r2_miss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o && !mispredict |=> !fetch_valid_o && $stable(fetch_addr_o));

  a_r4_next_from_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o |-> fetch_addr_o == fetch_next_o);

  a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict |=> squash_o && !fetch_valid_o && fetch_addr_o == $past(resolve_pc_i) + ADDR_W'(4));

  a_r7_squash_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> $past(mispredict));

  a_r9_call_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_valid_o && fetch_kind_o == KIND_CALL |-> link_valid_o && link_addr_o == fetch_pc_o + ADDR_W'(8));

  a_r10_port_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && wb_busy_i && !mispredict |=>
      !fetch_valid_o && $stable(fetch_addr_o) && link_valid_o && $stable(link_addr_o));

  a_r11_link_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_valid_o && !wb_busy_i |=> !link_valid_o || (fetch_valid_o && fetch_kind_o == KIND_CALL));
endmodule

bind pdc_fetch pdc_fetch_chk #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/pdc_fetch_tb.sv
module pdc_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid_i = 1'b0;
  logic [31:0] fill_addr_i = '0;
  logic [31:0] fill_instr_i = '0;
  logic [1:0]  fill_kind_i = '0;
  logic [31:0] fill_next_i = '0;
  logic        resolve_valid_i = 1'b0;
  logic        resolve_taken_i = 1'b0;
  logic [31:0] resolve_pc_i = '0;
  logic        wb_busy_i = 1'b0;
  logic [31:0] fetch_addr_o, fetch_pc_o, fetch_instr_o, fetch_next_o, link_addr_o;
  logic        miss_o, fetch_valid_o, squash_o, link_valid_o;
  logic [1:0]  fetch_kind_o;

  always #4 clk = ~clk;

  pdc_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid_i), .fill_addr_i(fill_addr_i), .fill_instr_i(fill_instr_i),
    .fill_kind_i(fill_kind_i), .fill_next_i(fill_next_i),
    .resolve_valid_i(resolve_valid_i), .resolve_taken_i(resolve_taken_i),
    .resolve_pc_i(resolve_pc_i), .wb_busy_i(wb_busy_i),
    .fetch_addr_o(fetch_addr_o), .miss_o(miss_o), .fetch_valid_o(fetch_valid_o),
    .fetch_pc_o(fetch_pc_o), .fetch_instr_o(fetch_instr_o), .fetch_kind_o(fetch_kind_o),
    .fetch_next_o(fetch_next_o), .squash_o(squash_o),
    .link_valid_o(link_valid_o), .link_addr_o(link_addr_o)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ins_of(input logic [31:0] a);
    return 32'hC300_0000 ^ a;
  endfunction

  typedef struct packed {
    logic [31:0] pc;
    logic [31:0] nxt;
    logic [1:0]  kind;
  } exp_t;
  exp_t q[$];
  exp_t e_m;

  task automatic push_exp(input logic [31:0] pc, input logic [1:0] k, input logic [31:0] n);
    q.push_back('{pc: pc, nxt: n, kind: k});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && fetch_valid_o) begin
      if (q.size() == 0) begin
        chk(1'b0, "R4", "unexpected delivery pc", fetch_pc_o, 32'hx);
      end else begin
        e_m = q.pop_front();
        chk(fetch_pc_o == e_m.pc, "R4", "delivered pc order", fetch_pc_o, e_m.pc);
        chk(fetch_instr_o == ins_of(e_m.pc), "R3", "instr", fetch_instr_o, ins_of(e_m.pc));
        chk(fetch_kind_o == e_m.kind, "R3", "kind", {30'd0, fetch_kind_o}, {30'd0, e_m.kind});
        chk(fetch_next_o == e_m.nxt, "R3", "successor", fetch_next_o, e_m.nxt);
        if (e_m.kind == 2'd2)
          chk(link_valid_o && link_addr_o == e_m.pc + 32'd8, "R9", "call link addr",
              link_addr_o, e_m.pc + 32'd8);
      end
    end
  end

  task automatic fill(input logic [31:0] a, input logic [1:0] k, input logic [31:0] n);
    fill_valid_i = 1'b1;
    fill_addr_i  = a;
    fill_instr_i = ins_of(a);
    fill_kind_i  = k;
    fill_next_i  = n;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!fetch_valid_o && !squash_o && !link_valid_o, "R1", "outputs in reset",
        {29'd0, fetch_valid_o, squash_o, link_valid_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!fetch_valid_o && !squash_o && !link_valid_o, "R1", "outputs after reset",
        {29'd0, fetch_valid_o, squash_o, link_valid_o}, 32'd0);
    chk(fetch_addr_o == 32'h0, "R1", "reset address", fetch_addr_o, 32'h0);
    chk(miss_o, "R2", "empty store misses", {31'd0, miss_o}, 32'd1);

    // phase 1: program with folded jump, branch and folded call
    fill(32'h04, 2'd0, 32'h08);
    fill(32'h08, 2'd1, 32'h20);
    fill(32'h20, 2'd3, 32'h30);
    fill(32'h30, 2'd0, 32'h34);
    fill(32'h34, 2'd2, 32'h10);
    fill(32'h10, 2'd0, 32'h14);
    chk(miss_o && !fetch_valid_o && fetch_addr_o == 32'h0, "R2", "held on miss",
        fetch_addr_o, 32'h0);
    push_exp(32'h00, 2'd0, 32'h04);
    push_exp(32'h04, 2'd0, 32'h08);
    push_exp(32'h08, 2'd1, 32'h20);
    push_exp(32'h20, 2'd3, 32'h30);
    push_exp(32'h30, 2'd0, 32'h34);
    push_exp(32'h34, 2'd2, 32'h10);
    push_exp(32'h10, 2'd0, 32'h14);
    fill(32'h00, 2'd0, 32'h04);
    repeat (7) @(negedge clk);
    chk(fetch_valid_o && fetch_pc_o == 32'h10, "R5", "seven entries in seven cycles (R6 no gap)",
        fetch_pc_o, 32'h10);
    @(negedge clk);
    chk(!fetch_valid_o && miss_o && fetch_addr_o == 32'h14, "R2", "stops at unfilled successor",
        fetch_addr_o, 32'h14);
    chk(q.size() == 0, "R4", "all phase 1 deliveries seen", q.size(), 32'd0);
    chk(!link_valid_o, "R11", "link retired with free port", {31'd0, link_valid_o}, 32'd0);

    // phase 2: branch resolves not taken while its target is looked up
    push_exp(32'h14, 2'd0, 32'h20);
    push_exp(32'h20, 2'd3, 32'h30);
    fill(32'h14, 2'd0, 32'h20);
    @(negedge clk);
    @(negedge clk);
    chk(fetch_valid_o && fetch_pc_o == 32'h20 && fetch_addr_o == 32'h30, "R6",
        "branch target looked up next", fetch_addr_o, 32'h30);
    resolve_valid_i = 1'b1;
    resolve_taken_i = 1'b0;
    resolve_pc_i    = 32'h20;
    @(negedge clk);
    resolve_valid_i = 1'b0;
    chk(squash_o && !fetch_valid_o, "R7", "target squashed",
        {30'd0, squash_o, fetch_valid_o}, 32'd2);
    chk(fetch_addr_o == 32'h24, "R7", "restart at fall-through", fetch_addr_o, 32'h24);
    @(negedge clk);
    chk(!squash_o, "R7", "squash strobe one cycle", {31'd0, squash_o}, 32'd0);
    chk(fetch_addr_o == 32'h24 && miss_o, "R2", "fall-through miss held", fetch_addr_o, 32'h24);

    // phase 3: tag mismatch and taken resolution
    push_exp(32'h24, 2'd0, 32'h40);
    fill(32'h24, 2'd0, 32'h40);
    @(negedge clk);
    @(negedge clk);
    chk(miss_o && !fetch_valid_o && fetch_addr_o == 32'h40, "R3", "same index other tag misses",
        fetch_addr_o, 32'h40);
    resolve_valid_i = 1'b1;
    resolve_taken_i = 1'b1;
    resolve_pc_i    = 32'h20;
    @(negedge clk);
    resolve_valid_i = 1'b0;
    chk(!squash_o && !fetch_valid_o && miss_o && fetch_addr_o == 32'h40, "R8",
        "taken outcome ignored", fetch_addr_o, 32'h40);

    // phase 4: folded call while the write port is busy
    wb_busy_i = 1'b1;
    fill(32'h50, 2'd0, 32'h54);
    push_exp(32'h40, 2'd2, 32'h50);
    push_exp(32'h50, 2'd0, 32'h54);
    fill(32'h40, 2'd2, 32'h50);
    @(negedge clk);
    chk(fetch_valid_o && link_valid_o && link_addr_o == 32'h48, "R9", "call delivered with link",
        link_addr_o, 32'h48);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(!fetch_valid_o && fetch_addr_o == 32'h50, "R10", "fetch stalled on busy port",
          fetch_addr_o, 32'h50);
      chk(link_valid_o && link_addr_o == 32'h48, "R10", "link held", link_addr_o, 32'h48);
    end
    wb_busy_i = 1'b0;
    @(negedge clk);
    chk(!link_valid_o, "R11", "link written when port free", {31'd0, link_valid_o}, 32'd0);
    chk(fetch_valid_o && fetch_pc_o == 32'h50, "R10", "fetch resumes", fetch_pc_o, 32'h50);
    @(negedge clk);
    chk(miss_o && fetch_addr_o == 32'h54, "R4", "sequential successor", fetch_addr_o, 32'h54);
    chk(q.size() == 0, "R4", "all deliveries seen", q.size(), 32'd0);

    finish_run();
  end
endmodule